// File: doc/BRIEF.md
# Video Capture Window Gate

This block sits in a video capture path, clocked by the pixel clock. It watches a horizontal and a vertical timing input and marks the rectangle of incoming video that is to be stored. It outputs a per-cycle pixel qualifier, the pixel and line position inside the rectangle, and, for interlaced sources, the identity of the current field. Each timing input has its own polarity select, and the rectangle is counted from the active edge of each input.

The start offsets, capture width, capture height, interlace mode and partial-frame policy are sampled once per frame, on the active vertical edge. A change made during capture therefore takes effect on the next frame. Each frame ends with one status pulse. The pulse is a completion, a completion flagged as short, or a discard when the frame was cut off and discard is enabled. A sticky error bit records any line or frame that ended before the programmed window fitted inside it.

The qualifier is a plain per-cycle flag, not a valid/ready stream. Live video cannot be held back, so there is no back-pressure input, and a consumer must take every qualified pixel in the cycle it is offered.

Top module: `cwg_window_gate`

## Requirements
- R1: A timing input is active low when its invert bit is 0 and active high when the bit is 1. An active edge is the first cycle in which the input is at its active level after a cycle at the inactive level.
- R2: The pixel count is 0 in the cycle after the clock edge that samples a horizontal active edge, and rises by 1 each cycle after that. `pix_valid` is high only on a window line and only while the pixel count is in [h_offset, h_offset + cap_width).
- R3: The line count is 0 after a vertical active edge and rises by 1 on each horizontal active edge. A line is a window line while the count is in [v_offset, v_offset + effective height) and a frame is open.
- R4: In interlaced mode the effective height is cap_height / 2 (rounded down) for each field, and the vertical offset applies inside each field. In progressive mode the effective height is cap_height.
- R5: At a vertical active edge, `field_odd` becomes 1 when interlaced mode is set, no horizontal edge is seen in the same cycle, and the pixel count is at least half the last measured line length. Otherwise it becomes 0. It then holds until the next vertical edge.
- R6: h_offset, cap_width, v_offset, cap_height, interlace and drop_partial are taken only at a vertical active edge. Changing them in mid-frame does not alter the frame in progress.
- R7: When the horizontal edge that ends the last window line arrives, `frame_done` pulses for one cycle with `frame_short` low, and the frame closes.
- R8: If a vertical edge arrives while a frame is still open and discard was enabled for that frame, `frame_drop` pulses for one cycle and `frame_done` stays low.
- R9: If a vertical edge arrives while a frame is still open and discard was disabled for that frame, `frame_done` and `frame_short` pulse together for one cycle.
- R10: `window_err` is set, and stays set until reset, when a window line ends before pixel count h_offset + cap_width is reached, or when a frame is cut off (R8, R9). Pixels past the line end are simply not produced.
- R11: While `pix_valid` is high, `pix_idx` equals the pixel count minus h_offset and `line_idx` equals the line count minus v_offset.
- R12: During and after reset, before any timing edge, `pix_valid`, `field_odd`, `frame_done`, `frame_short`, `frame_drop` and `window_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_in | input | 1 | Horizontal timing input |
| vs_in | input | 1 | Vertical timing input |
| hs_invert | input | 1 | 1 makes hs_in active high |
| vs_invert | input | 1 | 1 makes vs_in active high |
| interlace | input | 1 | Interlaced source |
| drop_partial | input | 1 | Discard frames that are cut off |
| h_offset | input | PIX_W | Horizontal start, in pixel clocks after the horizontal edge |
| cap_width | input | PIX_W | Pixels taken per line |
| v_offset | input | LINE_W | Vertical start, in lines after the vertical edge |
| cap_height | input | LINE_W | Lines per frame (per frame, not per field) |
| pix_valid | output | 1 | Current cycle is inside the window |
| field_odd | output | 1 | Field identity of the current field |
| pix_idx | output | PIX_W | Pixel position inside the window |
| line_idx | output | LINE_W | Line position inside the window |
| frame_done | output | 1 | One-cycle pulse: frame finished |
| frame_short | output | 1 | With frame_done: the frame was cut off |
| frame_drop | output | 1 | One-cycle pulse: cut-off frame discarded |
| window_err | output | 1 | Sticky window-fit error |

## Verification
The bench builds the gate with PIX_W=10 and LINE_W=8 and drives lines 40 clocks long in frames of 6 to 12 lines. This keeps a frame under 500 cycles, so one run covers progressive frames, both field phases, both input polarities, a mid-frame register change, cut-off frames under both policies and a window wider than the line. A behavioural model compares every output on every clock. Directed totals of qualified pixels and status pulses then tie each scenario to its requirement.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_FULL  = 2'd1,
    END_SHORT = 2'd2,
    END_DROP  = 2'd3
  } frame_end_e;
endpackage

// File: rtl/cwg_edge.sv
module cwg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_raw,
  input  logic invert,
  output logic act_edge
);
  logic act;
  logic act_q;

  // active level: low by default, high when invert is set
  assign act = sig_raw ~^ invert;
  assign act_edge = act & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end
endmodule

// File: rtl/cwg_hcount.sv
module cwg_hcount #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_edge,
  output logic [PIX_W-1:0] pcnt,
  output logic [PIX_W-1:0] line_len
);
  localparam logic [PIX_W-1:0] P_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      line_len <= '0;
    end else if (h_edge) begin
      pcnt     <= '0;
      line_len <= (pcnt == P_MAX) ? P_MAX : pcnt + 1'b1;
    end else if (pcnt != P_MAX) begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/cwg_vcount.sv
module cwg_vcount
  import cwg_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_edge,
  input  logic              v_edge,
  input  logic [PIX_W-1:0]  pcnt,
  input  logic [PIX_W-1:0]  line_len,
  input  logic              interlace,
  input  logic              drop_partial,
  input  logic [PIX_W-1:0]  h_offset,
  input  logic [PIX_W-1:0]  cap_width,
  input  logic [LINE_W-1:0] v_offset,
  input  logic [LINE_W-1:0] cap_height,
  output logic              line_open,
  output logic [PIX_W-1:0]  h_lo,
  output logic [PIX_W:0]    h_hi,
  output logic [LINE_W-1:0] line_idx,
  output logic              field_odd,
  output logic              frame_done,
  output logic              frame_short,
  output logic              frame_drop,
  output logic              window_err
);
  localparam logic [LINE_W-1:0] L_MAX = '1;
  localparam logic [LINE_W:0]   L_ONE = {{LINE_W{1'b0}}, 1'b1};
  localparam logic [PIX_W:0]    P_ONE = {{PIX_W{1'b0}}, 1'b1};

  // per-frame shadow copies of the window registers
  logic [PIX_W-1:0]  hoff_s;
  logic [PIX_W:0]    hend_s;
  logic [LINE_W-1:0] voff_s;
  logic [LINE_W:0]   vend_s;
  logic              drop_s;

  logic [LINE_W-1:0] lcnt;
  logic              armed;
  logic              field_q;
  logic              err_q;
  frame_end_e        end_q;

  logic [LINE_W-1:0] eff_h;
  logic              row_in;
  logic              complete;
  logic              cut_off;
  logic              line_short;

  assign eff_h      = interlace ? (cap_height >> 1) : cap_height;
  assign row_in     = armed && (lcnt >= voff_s) && ({1'b0, lcnt} < vend_s);
  assign complete   = armed && h_edge && (({1'b0, lcnt} + L_ONE) == vend_s);
  assign cut_off    = armed && v_edge && !complete;
  assign line_short = h_edge && row_in && (({1'b0, pcnt} + P_ONE) < hend_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hoff_s  <= '0;
      hend_s  <= '0;
      voff_s  <= '0;
      vend_s  <= '0;
      drop_s  <= 1'b0;
      lcnt    <= '0;
      armed   <= 1'b0;
      field_q <= 1'b0;
    end else if (v_edge) begin
      hoff_s  <= h_offset;
      hend_s  <= {1'b0, h_offset} + {1'b0, cap_width};
      voff_s  <= v_offset;
      vend_s  <= {1'b0, v_offset} + {1'b0, eff_h};
      drop_s  <= drop_partial;
      lcnt    <= '0;
      armed   <= (eff_h != '0);
      field_q <= interlace && !h_edge && (pcnt >= (line_len >> 1));
    end else if (h_edge) begin
      if (lcnt != L_MAX) lcnt <= lcnt + 1'b1;
      if (complete) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= END_NONE;
      err_q <= 1'b0;
    end else begin
      if (complete)     end_q <= END_FULL;
      else if (cut_off) end_q <= drop_s ? END_DROP : END_SHORT;
      else              end_q <= END_NONE;
      err_q <= err_q | line_short | cut_off;
    end
  end

  assign line_open   = row_in;
  assign h_lo        = hoff_s;
  assign h_hi        = hend_s;
  assign line_idx    = lcnt - voff_s;
  assign field_odd   = field_q;
  assign frame_done  = (end_q == END_FULL) || (end_q == END_SHORT);
  assign frame_short = (end_q == END_SHORT);
  assign frame_drop  = (end_q == END_DROP);
  assign window_err  = err_q;

  assert_done_drop_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_drop));
  assert_short_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_short |-> frame_done);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    window_err |=> window_err);
  assert_field_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !v_edge |=> $stable(field_odd));
  assert_no_end_when_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !(frame_done || frame_drop));
endmodule

// File: rtl/cwg_window_gate.sv
module cwg_window_gate #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              hs_invert,
  input  logic              vs_invert,
  input  logic              interlace,
  input  logic              drop_partial,
  input  logic [PIX_W-1:0]  h_offset,
  input  logic [PIX_W-1:0]  cap_width,
  input  logic [LINE_W-1:0] v_offset,
  input  logic [LINE_W-1:0] cap_height,
  output logic              pix_valid,
  output logic              field_odd,
  output logic [PIX_W-1:0]  pix_idx,
  output logic [LINE_W-1:0] line_idx,
  output logic              frame_done,
  output logic              frame_short,
  output logic              frame_drop,
  output logic              window_err
);
  localparam int N_SYNC = 2;

  logic [N_SYNC-1:0] raw_v;
  logic [N_SYNC-1:0] inv_v;
  logic [N_SYNC-1:0] edge_v;
  logic              h_edge;
  logic              v_edge;

  assign raw_v = {vs_in, hs_in};
  assign inv_v = {vs_invert, hs_invert};

  for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_sync
    cwg_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_raw  (raw_v[gi]),
      .invert   (inv_v[gi]),
      .act_edge (edge_v[gi])
    );
  end

  assign h_edge = edge_v[0];
  assign v_edge = edge_v[1];

  logic [PIX_W-1:0] pcnt;
  logic [PIX_W-1:0] line_len;
  logic             line_open;
  logic [PIX_W-1:0] h_lo;
  logic [PIX_W:0]   h_hi;

  cwg_hcount #(.PIX_W(PIX_W)) u_h (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_edge   (h_edge),
    .pcnt     (pcnt),
    .line_len (line_len)
  );

  cwg_vcount #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_v (
    .clk          (clk),
    .rst_n        (rst_n),
    .h_edge       (h_edge),
    .v_edge       (v_edge),
    .pcnt         (pcnt),
    .line_len     (line_len),
    .interlace    (interlace),
    .drop_partial (drop_partial),
    .h_offset     (h_offset),
    .cap_width    (cap_width),
    .v_offset     (v_offset),
    .cap_height   (cap_height),
    .line_open    (line_open),
    .h_lo         (h_lo),
    .h_hi         (h_hi),
    .line_idx     (line_idx),
    .field_odd    (field_odd),
    .frame_done   (frame_done),
    .frame_short  (frame_short),
    .frame_drop   (frame_drop),
    .window_err   (window_err)
  );

  assign pix_valid = line_open && (pcnt >= h_lo) && ({1'b0, pcnt} < h_hi);
  assign pix_idx   = pcnt - h_lo;

  assert_pix_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid) && !$past(h_edge)) |-> (pix_idx == $past(pix_idx) + 1'b1));
  assert_line_idx_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid) && !$past(h_edge) && !$past(v_edge)) |-> $stable(line_idx));
endmodule

// File: tb/cwg_window_gate_tb_top.sv
`timescale 1ns/1ps
module cwg_window_gate_tb_top;
  localparam int PW = 10;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic hs = 1'b1, vs = 1'b1, hinv = 1'b0, vinv = 1'b0, ilace = 1'b0, dropen = 1'b0;
  logic [PW-1:0] hoff = 10'd5, wid = 10'd20;
  logic [LW-1:0] voff = 8'd3, hgt = 8'd6;

  logic pix_valid, field_odd, frame_done, frame_short, frame_drop, window_err;
  logic [PW-1:0] pix_idx;
  logic [LW-1:0] line_idx;

  cwg_window_gate #(.PIX_W(PW), .LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hs_in(hs), .vs_in(vs),
    .hs_invert(hinv), .vs_invert(vinv), .interlace(ilace), .drop_partial(dropen),
    .h_offset(hoff), .cap_width(wid), .v_offset(voff), .cap_height(hgt),
    .pix_valid(pix_valid), .field_odd(field_odd), .pix_idx(pix_idx), .line_idx(line_idx),
    .frame_done(frame_done), .frame_short(frame_short), .frame_drop(frame_drop),
    .window_err(window_err)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_hp, m_vp, m_arm, m_field, m_err, m_done, m_short, m_dropp, m_drop;
  int m_pc, m_ll, m_lc, m_H, m_W, m_V, m_HE;
  always @(posedge clk) begin
    bit ha, va, he, ve, row, comp, cut;
    if (!rst_n) begin
      m_hp = 0; m_vp = 0; m_arm = 0; m_field = 0; m_err = 0;
      m_done = 0; m_short = 0; m_dropp = 0; m_drop = 0;
      m_pc = 0; m_ll = 0; m_lc = 0; m_H = 0; m_W = 0; m_V = 0; m_HE = 0;
    end else begin
      ha = hinv ? hs : !hs;
      va = vinv ? vs : !vs;
      he = ha && !m_hp;
      ve = va && !m_vp;
      m_hp = ha; m_vp = va;
      row  = m_arm && m_lc >= m_V && m_lc < m_V + m_HE;
      comp = m_arm && he && (m_lc + 1 == m_V + m_HE);
      cut  = m_arm && ve && !comp;
      m_done  = comp || (cut && !m_drop);
      m_short = cut && !m_drop;
      m_dropp = cut && m_drop;
      if (he && row && (m_pc + 1 < m_H + m_W)) m_err = 1;
      if (cut) m_err = 1;
      if (ve) begin
        m_field = ilace && !he && (m_pc >= m_ll / 2);
        m_H = int'(hoff); m_W = int'(wid); m_V = int'(voff);
        m_HE = ilace ? int'(hgt) / 2 : int'(hgt);
        m_drop = dropen;
        m_lc = 0;
        m_arm = (m_HE != 0);
      end else if (he) begin
        m_lc++;
        if (comp) m_arm = 0;
      end
      if (he) begin m_ll = m_pc + 1; m_pc = 0; end
      else m_pc++;
    end
  end

  int pv_cnt = 0, done_cnt = 0, short_cnt = 0, drop_cnt = 0;
  always @(negedge clk) begin
    bit pv_e;
    if (rst_n) begin
      pv_e = m_arm && m_lc >= m_V && m_lc < m_V + m_HE && m_pc >= m_H && m_pc < m_H + m_W;
      chk(pix_valid == pv_e, "R2 pix_valid", int'(pix_valid), int'(pv_e));
      chk(field_odd == m_field, "R5 field_odd", int'(field_odd), int'(m_field));
      chk(frame_done == m_done, "R7 frame_done", int'(frame_done), int'(m_done));
      chk(frame_short == m_short, "R9 frame_short", int'(frame_short), int'(m_short));
      chk(frame_drop == m_dropp, "R8 frame_drop", int'(frame_drop), int'(m_dropp));
      chk(window_err == m_err, "R10 window_err", int'(window_err), int'(m_err));
      if (pv_e) begin
        chk(int'(pix_idx) == m_pc - m_H, "R11 pix_idx", int'(pix_idx), m_pc - m_H);
        chk(int'(line_idx) == m_lc - m_V, "R11 line_idx", int'(line_idx), m_lc - m_V);
      end
      if (pix_valid) pv_cnt++;
      if (frame_done) done_cnt++;
      if (frame_short) short_cnt++;
      if (frame_drop) drop_cnt++;
    end
  end

  task automatic zero_counts();
    pv_cnt = 0; done_cnt = 0; short_cnt = 0; drop_cnt = 0;
  endtask

  task automatic set_pol(input logic h, input logic v);
    hinv = h; vinv = v;
    hs = h ? 1'b0 : 1'b1;
    vs = v ? 1'b0 : 1'b1;
  endtask

  task automatic send_frame(input int ll, input int nl, input int vph,
                            input int poke_line, input int poke_w);
    for (int l = 0; l < nl; l++) begin
      for (int p = 0; p < ll; p++) begin
        bit ha, va;
        @(negedge clk);
        if (l == poke_line && p == 0) wid = poke_w[PW-1:0];
        ha = (p < 4);
        va = (l == 0 && p >= vph) || (l == 1 && p < vph);
        hs = hinv ? ha : !ha;
        vs = vinv ? va : !va;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    set_pol(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk({pix_valid, field_odd, frame_done, frame_short, frame_drop, window_err} == 6'b0,
        "R12 reset outputs",
        int'({pix_valid, field_odd, frame_done, frame_short, frame_drop, window_err}), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    do_reset();

    // progressive window, active-low timing (R2, R3, R7)
    zero_counts();
    for (int f = 0; f < 3; f++) send_frame(40, 12, 0, -1, 0);
    chk(pv_cnt == 360, "R3 window pixels progressive", pv_cnt, 360);
    chk(done_cnt == 3, "R7 completions", done_cnt, 3);

    // inverted polarity on both inputs (R1)
    set_pol(1'b1, 1'b1);
    zero_counts();
    for (int f = 0; f < 2; f++) send_frame(40, 12, 0, -1, 0);
    chk(pv_cnt == 240, "R1 inverted polarity pixels", pv_cnt, 240);
    chk(done_cnt == 2, "R1 inverted polarity completions", done_cnt, 2);
    set_pol(1'b0, 1'b0);

    // interlaced fields alternating phase (R4, R5)
    ilace = 1'b1;
    zero_counts();
    for (int f = 0; f < 4; f++) begin
      int ph;
      ph = (f % 2 == 1) ? 24 : 0;
      send_frame(40, 10, ph, -1, 0);
      chk(field_odd == (ph == 24), "R5 field phase", int'(field_odd), int'(ph == 24));
    end
    chk(pv_cnt == 240, "R4 half height per field", pv_cnt, 240);
    chk(done_cnt == 4, "R4 field completions", done_cnt, 4);
    ilace = 1'b0;

    // width changed in mid-frame takes effect next frame (R6)
    zero_counts();
    send_frame(40, 12, 0, 5, 30);
    chk(pv_cnt == 120, "R6 mid-frame change ignored", pv_cnt, 120);
    send_frame(40, 12, 0, -1, 0);
    chk(pv_cnt == 300, "R6 change applied next frame", pv_cnt, 300);
    wid = 10'd20;

    // cut-off frame reported short (R9, R10)
    zero_counts();
    send_frame(40, 6, 0, -1, 0);
    send_frame(40, 12, 0, -1, 0);
    chk(short_cnt == 1, "R9 short flagged", short_cnt, 1);
    chk(done_cnt == 2, "R9 short counts as done", done_cnt, 2);
    chk(window_err == 1'b1, "R10 error after cut-off", int'(window_err), 1);

    // cut-off frame discarded (R8)
    dropen = 1'b1;
    zero_counts();
    send_frame(40, 6, 0, -1, 0);
    send_frame(40, 12, 0, -1, 0);
    chk(drop_cnt == 1, "R8 discard pulse", drop_cnt, 1);
    chk(done_cnt == 1, "R8 no done for discarded", done_cnt, 1);
    dropen = 1'b0;

    // window wider than the line: clip and error (R10)
    hoff = 10'd30;
    do_reset();
    zero_counts();
    send_frame(40, 12, 0, -1, 0);
    send_frame(40, 12, 0, -1, 0);
    chk(pv_cnt == 120, "R10 clipped pixels", pv_cnt, 120);
    chk(window_err == 1'b1, "R10 line overflow error", int'(window_err), 1);

    finish_run();
  end
endmodule